// File: doc/BRIEF.md
# Comparator Output Conditioner with Edge Interrupt

This block sits on the digital side of an analog voltage comparator. The comparator's one-bit result arrives asynchronously. The block synchronises it into the CPU clock domain and passes it through a programmable stability filter. The filtered value is exposed as a readable status bit and can optionally be driven onto an output pin. The filter only accepts a new level once the synchronised input has held it for an even number of cycles, chosen by a delay select field.

Transitions of the filtered result feed two consumers. The first is a sticky interrupt flag that responds to the edge direction software has selected. The flag stays latched through low-power periods until software clears it with a write-one strobe. The second is a single-cycle request to a PWM timer to raise its reload value, which narrows the timer's pulse. This request is issued on each rising edge of the filtered result, but only while the timer reports its output as enabled and shrinking has been selected.

Top module: `cmpc_cond`

## Requirements
- R1: While reset is asserted and until the first accepted input change afterwards, `status`, `pin_out`, `pin_oe` (with `out_en` low), `irq` and `shrink_req` are 0.
- R2: With `dly_sel` = 0 and `en` = 1, `status` takes the new level of `raw_in` exactly 3 clock edges after `raw_in` changes, where 2 edges are spent in the synchroniser and 1 in the filter register.
- R3: With `dly_sel` = N, a stable change of `raw_in` reaches `status` exactly 2N+3 clock edges after it is applied, and not earlier. This holds for N from 1 up to the field maximum of 15, which gives a 30-cycle window.
- R4: A synchronised pulse shorter than 2N cycles leaves `status` unchanged, and a later stable change needs the full 2N+3 edges again.
- R5: `irq` is set one edge after `status` makes a transition in the direction chosen by `edge_sel` (1 = low-to-high, 0 = high-to-low). A transition in the other direction does not set it.
- R6: Once set, `irq` stays 1 until a cycle in which `irq_clr` is 1, and reads 0 on the following edge.
- R7: If a set event and `irq_clr` fall in the same cycle, `irq` is 1 after that edge.
- R8: `shrink_req` is a one-cycle pulse in the cycle in which `status` first reads 1, issued only when `shrink_sel` = 1, `tmr_out_en` = 1 and `en` = 1. Otherwise it stays 0.
- R9: `pin_oe` equals `out_en`. `pin_out` equals `status` when `out_en` = 1 and is 0 when `out_en` = 0.
- R10: With `en` = 0, `status` and `shrink_req` are 0 and no new `irq` event is recorded, while an `irq` that is already set is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| dly_sel | input | DLY_W | Stability window select, window = 2 x value cycles |
| edge_sel | input | 1 | Interrupt edge: 1 rising, 0 falling |
| shrink_sel | input | 1 | Select comparator as pulse-shrink trigger |
| out_en | input | 1 | Route conditioned result to the pin |
| tmr_out_en | input | 1 | Timer PWM output is enabled |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| raw_in | input | 1 | Raw comparator result, asynchronous |
| status | output | 1 | Conditioned comparator level |
| pin_out | output | 1 | Pin data, low when not routed |
| pin_oe | output | 1 | Pin driver enable |
| irq | output | 1 | Sticky interrupt request |
| shrink_req | output | 1 | One-cycle request to raise the timer reload value |

## Verification
The bench builds the block with its defaults, a 4-bit delay field and a two-stage synchroniser. With these values every window from 0 to 30 cycles is reachable, and the bench exercises the zero case, small windows and the 30-cycle maximum at exact edge counts. The two-stage synchroniser fixes the fixed latency term at 3 edges, so the expected timing of each sample is computed as 2N+3 with no dependence on internals. Glitch restart, both interrupt edge directions, same-cycle set-versus-clear and each gate on the shrink request are driven as separate directed scenarios.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_dir_e;
endpackage

// File: rtl/cmpc_rst_sync.sv
module cmpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= stg_d;
  end

  assign rst_n_sync = stg_q[1];
endmodule

// File: rtl/cmpc_sync.sv
module cmpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_in;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/cmpc_filter.sv
module cmpc_filter #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DLY_W-1:0] dly_sel,
  input  logic             s_in,
  output logic             level,
  output logic             rise_p,
  output logic             fall_p
);
  localparam int CNT_W = DLY_W + 1;

  logic [CNT_W-1:0] win;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             rise_q, rise_d;
  logic             fall_q, fall_d;

  // window length is twice the select value
  assign win = {dly_sel, 1'b0};

  always_comb begin
    lvl_d  = lvl_q;
    cnt_d  = cnt_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (!en) begin
      lvl_d = 1'b0;
      cnt_d = '0;
    end else if (s_in == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q >= win) begin
      lvl_d  = s_in;
      cnt_d  = '0;
      rise_d = s_in;
      fall_d = ~s_in;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      cnt_q  <= cnt_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign level  = lvl_q;
  assign rise_p = rise_q;
  assign fall_p = fall_q;
endmodule

// File: rtl/cmpc_irq.sv
module cmpc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  // set has priority over a simultaneous clear
  always_comb begin
    flag_d = flag_q;
    if (clr)    flag_d = 1'b0;
    if (set_ev) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/cmpc_cond.sv
module cmpc_cond
  import cmpc_pkg::*;
#(
  parameter int DLY_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DLY_W-1:0] dly_sel,
  input  logic             edge_sel,
  input  logic             shrink_sel,
  input  logic             out_en,
  input  logic             tmr_out_en,
  input  logic             irq_clr,
  input  logic             raw_in,
  output logic             status,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             irq,
  output logic             shrink_req
);
  logic      rst_n_int;
  logic      s_raw;
  logic      lvl;
  logic      rise_p, fall_p;
  logic      set_ev;
  edge_dir_e edge_dir;

  cmpc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cmpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_in  (raw_in),
    .d_out (s_raw)
  );

  cmpc_filter #(.DLY_W(DLY_W)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en      (en),
    .dly_sel (dly_sel),
    .s_in    (s_raw),
    .level   (lvl),
    .rise_p  (rise_p),
    .fall_p  (fall_p)
  );

  assign edge_dir = edge_dir_e'(edge_sel);

  always_comb begin
    set_ev = 1'b0;
    if (en) begin
      case (edge_dir)
        EDGE_RISE: set_ev = rise_p;
        default:   set_ev = fall_p;
      endcase
    end
  end

  cmpc_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .set_ev (set_ev),
    .clr    (irq_clr),
    .flag   (irq)
  );

  assign status     = en & lvl;
  assign pin_oe     = out_en;
  assign pin_out    = out_en & status;
  assign shrink_req = en & shrink_sel & tmr_out_en & rise_p;
endmodule

// File: rtl/cmpc_cond_chk.sv
module cmpc_cond_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic edge_sel,
  input logic shrink_sel,
  input logic out_en,
  input logic tmr_out_en,
  input logic irq_clr,
  input logic status,
  input logic pin_out,
  input logic pin_oe,
  input logic irq,
  input logic shrink_req
);
  assert_pin_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out |-> (status && pin_oe));

  assert_shrink_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shrink_req |=> !shrink_req);

  assert_shrink_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shrink_req |-> (status && !$past(status)));

  assert_shrink_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shrink_req |-> (tmr_out_en && shrink_sel));

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_irq_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(edge_sel) ? ($past(status) && !$past(status, 2))
                                    : (!$past(status) && $past(status, 2))));

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!status && !shrink_req));
endmodule

bind cmpc_cond cmpc_cond_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .edge_sel   (edge_sel),
  .shrink_sel (shrink_sel),
  .out_en     (out_en),
  .tmr_out_en (tmr_out_en),
  .irq_clr    (irq_clr),
  .status     (status),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .irq        (irq),
  .shrink_req (shrink_req)
);

// File: tb/tb_cmpc_cond.sv
module tb_cmpc_cond;
  localparam int DLY_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             en, edge_sel, shrink_sel, out_en, tmr_out_en, irq_clr, raw_in;
  logic [DLY_W-1:0] dly_sel;
  logic             status, pin_out, pin_oe, irq, shrink_req;

  int checks   = 0;
  int failures = 0;

  always #5 clk = ~clk;

  cmpc_cond #(.DLY_W(DLY_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dly_sel(dly_sel), .edge_sel(edge_sel),
    .shrink_sel(shrink_sel), .out_en(out_en), .tmr_out_en(tmr_out_en),
    .irq_clr(irq_clr), .raw_in(raw_in), .status(status), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq), .shrink_req(shrink_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // k rising edges, then sit on the following falling edge
  task automatic go(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1; go(1); irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b1; dly_sel = '0; edge_sel = 1'b1; shrink_sel = 1'b0;
    out_en = 1'b0; tmr_out_en = 1'b0; irq_clr = 1'b0; raw_in = 1'b0;
    go(3);
    chk("R1", "status in reset", status, 0);
    chk("R1", "irq in reset", irq, 0);
    chk("R1", "shrink in reset", shrink_req, 0);
    chk("R1", "pin in reset", {pin_out, pin_oe}, 0);
    rst_n = 1'b1;
    go(4);
    chk("R1", "status after reset", status, 0);
    chk("R1", "irq after reset", irq, 0);
  endtask

  task automatic t_nodelay();
    dly_sel = '0; raw_in = 1'b1;
    go(2); chk("R2", "status before 3 edges", status, 0);
    go(1); chk("R2", "status at 3 edges", status, 1);
    raw_in = 1'b0;
    go(2); chk("R2", "status before fall", status, 1);
    go(1); chk("R2", "status fall at 3 edges", status, 0);
  endtask

  task automatic t_delay(input int n);
    int lat;
    lat = 2 * n + 3;
    dly_sel = DLY_W'(n); raw_in = 1'b1;
    go(lat - 1); chk("R3", $sformatf("rise early n=%0d", n), status, 0);
    go(1);       chk("R3", $sformatf("rise on time n=%0d", n), status, 1);
    raw_in = 1'b0;
    go(lat - 1); chk("R3", $sformatf("fall early n=%0d", n), status, 1);
    go(1);       chk("R3", $sformatf("fall on time n=%0d", n), status, 0);
  endtask

  task automatic t_glitch();
    logic moved;
    moved = 1'b0;
    dly_sel = DLY_W'(3); raw_in = 1'b1;
    go(4); raw_in = 1'b0;
    for (int i = 0; i < 20; i++) begin
      go(1);
      if (status) moved = 1'b1;
    end
    chk("R4", "short pulse filtered", moved, 0);
    raw_in = 1'b1;
    go(8); chk("R4", "count restarted, not early", status, 0);
    go(1); chk("R4", "count restarted, full window", status, 1);
    raw_in = 1'b0; go(10);
  endtask

  task automatic t_irq();
    dly_sel = '0; edge_sel = 1'b1;
    clear_irq();
    chk("R6", "cleared", irq, 0);
    raw_in = 1'b1;
    go(3); chk("R5", "irq not before edge+1", irq, 0);
    go(1); chk("R5", "irq on rising edge", irq, 1);
    raw_in = 1'b0;
    go(5); chk("R6", "irq sticky", irq, 1);
    clear_irq();
    chk("R6", "irq cleared by strobe", irq, 0);
    edge_sel = 1'b0; raw_in = 1'b1;
    go(5); chk("R5", "rising ignored when falling selected", irq, 0);
    raw_in = 1'b0;
    go(4); chk("R5", "irq on falling edge", irq, 1);
    clear_irq();
    raw_in = 1'b1; go(5);
    raw_in = 1'b0; go(3);
    irq_clr = 1'b1; go(1); irq_clr = 1'b0;
    chk("R7", "set wins over clear", irq, 1);
    clear_irq();
    chk("R6", "cleared again", irq, 0);
    edge_sel = 1'b1;
  endtask

  task automatic t_shrink();
    logic seen;
    dly_sel = '0; shrink_sel = 1'b1; tmr_out_en = 1'b1; raw_in = 1'b1;
    go(2); chk("R8", "no request before rise", shrink_req, 0);
    go(1); chk("R8", "request with rise", shrink_req, 1);
    go(1); chk("R8", "request one cycle", shrink_req, 0);
    raw_in = 1'b0; go(4);
    tmr_out_en = 1'b0; raw_in = 1'b1; seen = 1'b0;
    for (int i = 0; i < 5; i++) begin go(1); if (shrink_req) seen = 1'b1; end
    chk("R8", "blocked by timer output off", seen, 0);
    raw_in = 1'b0; go(4);
    tmr_out_en = 1'b1; shrink_sel = 1'b0; raw_in = 1'b1; seen = 1'b0;
    for (int i = 0; i < 5; i++) begin go(1); if (shrink_req) seen = 1'b1; end
    chk("R8", "blocked by select off", seen, 0);
    raw_in = 1'b0; go(4);
  endtask

  task automatic t_pin();
    raw_in = 1'b1; go(4);
    out_en = 1'b0; go(1);
    chk("R9", "pin low when not routed", pin_out, 0);
    chk("R9", "pin driver off", pin_oe, 0);
    out_en = 1'b1; go(1);
    chk("R9", "pin follows status", pin_out, 1);
    chk("R9", "pin driver on", pin_oe, 1);
    raw_in = 1'b0; go(4);
    chk("R9", "pin follows low status", pin_out, 0);
  endtask

  task automatic t_enable();
    logic seen;
    edge_sel = 1'b1; shrink_sel = 1'b1; tmr_out_en = 1'b1;
    clear_irq();
    raw_in = 1'b1; go(4);
    chk("R10", "irq armed while enabled", irq, 1);
    en = 1'b0; go(1);
    chk("R10", "status off when disabled", status, 0);
    chk("R10", "existing irq kept", irq, 1);
    clear_irq();
    raw_in = 1'b0; go(4);
    raw_in = 1'b1; seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      go(1);
      if (status || shrink_req || irq) seen = 1'b1;
    end
    chk("R10", "no status, request or irq while disabled", seen, 0);
    en = 1'b1; raw_in = 1'b0; go(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_nodelay();
    t_delay(1);
    t_delay(5);
    t_delay(15);
    t_glitch();
    t_irq();
    t_shrink();
    t_pin();
    t_enable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule